// File: doc/BRIEF.md
# PWM Trip-Zone Fault Controller

This block sits between a PWM waveform generator and the output pads. It watches a set of fault inputs and, as soon as an enabled one is asserted, replaces each of the two PWM signals with a chosen safe state: driven high, driven low, released to high-impedance, toggling, or left as it is. The replacement is combinational from the fault input, so protection does not wait for any clocked stage or for software.

Each fault input can be assigned to two trip classes. The latched class is for severe faults such as a short circuit: once seen, it stays in force until software issues a clear while the fault is gone. The cycle-by-cycle class is for current limiting: it stays in force only until the first counter-zero strobe after the fault input has dropped, so the next PWM period starts clean. When both classes are active, the latched class sets the outputs. The block also keeps a sticky record of every fault input it has seen and can raise an interrupt when a trip occurs.

Top module: `tz_guard`

## Requirements
- R1: After reset, both outputs follow their PWM inputs with output enables high, and the source flags, both class flags and the interrupt are 0.
- R2: With no trip in force, pwm_a_out and pwm_b_out equal pwm_a_in and pwm_b_in in the same cycle, and oe_a and oe_b are 1.
- R3: When fault_in[i] is 1 with os_en[i] set, the latched action is applied in the same cycle; os_flag rises on the next edge and stays 1 after the input drops until a cycle with sw_clr=1, after which it reads 0.
- R4: sw_clr has no effect on the latched trip in any cycle where an input enabled for the latched class is still 1.
- R5: When fault_in[i] is 1 with cb_en[i] set, the cycle-by-cycle action is applied in the same cycle; cb_flag rises on the next edge and stays 1 until the first edge with ctr_zero=1 and no enabled cycle-by-cycle input, and a ctr_zero during the fault does not release it.
- R6: When both classes are in force, the latched action selects the outputs, even when that action is pass.
- R7: Action codes per output: 0 pass the input, 1 drive 1, 2 drive 0, 3 high-impedance (oe=0, data 0), 4 toggle, 5 to 7 drive 0; oe is 0 only under code 3.
- R8: Each output holds a toggle bit that is the inverse of its PWM input of the previous cycle while toggle is not in force; under toggle the output shows that bit, which inverts at every edge with ctr_zero=1.
- R9: A fault input with both of its enable bits at 0 changes neither output.
- R10: src_flags[i] becomes 1 on the edge after fault_in[i] is 1, whatever the enables; sw_clr clears it only if fault_in[i] is 0 in that cycle.
- R11: irq becomes 1 on the edge after a cycle with irq_en=1 and any enabled fault input at 1, holds until sw_clr in a cycle without such a fault, and never rises with irq_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_a_in | input | 1 | PWM signal A from the generator |
| pwm_b_in | input | 1 | PWM signal B from the generator |
| fault_in | input | NSRC | Fault inputs, active high |
| os_en | input | NSRC | Per input: assign to the latched class |
| cb_en | input | NSRC | Per input: assign to the cycle-by-cycle class |
| os_act_a | input | 3 | Latched-class action for output A |
| os_act_b | input | 3 | Latched-class action for output B |
| cb_act_a | input | 3 | Cycle-by-cycle action for output A |
| cb_act_b | input | 3 | Cycle-by-cycle action for output B |
| ctr_zero | input | 1 | One-cycle strobe at PWM counter zero |
| sw_clr | input | 1 | Software clear of latch, flags and interrupt |
| irq_en | input | 1 | Interrupt enable |
| pwm_a_out | output | 1 | Output A after override |
| pwm_b_out | output | 1 | Output B after override |
| oe_a | output | 1 | Pad drive enable for A, 0 = high-impedance |
| oe_b | output | 1 | Pad drive enable for B, 0 = high-impedance |
| src_flags | output | NSRC | Sticky record of seen fault inputs |
| os_flag | output | 1 | Latched trip state |
| cb_flag | output | 1 | Cycle-by-cycle trip state |
| irq | output | 1 | Interrupt request |

## Verification
The PWM inputs run a changing pattern throughout, so pass-through and override are told apart every cycle. A single-input fault is applied to each class alone, which separates the self-releasing behaviour (counter-zero strobes before and after the input drops) from the latched one (clears issued while the input is high and after it drops). Overlapping faults on both classes with opposite actions show which class wins, an all-inputs fault with zero enables shows that masking holds while the flags still record, and a sweep of all eight action codes on both outputs covers the encoding, including toggle stepping on counter-zero.

// File: rtl/tz_pkg.sv
package tz_pkg;
    localparam int ACT_W = 3;
    localparam logic [ACT_W-1:0] ACT_PASS   = 3'd0;
    localparam logic [ACT_W-1:0] ACT_HIGH   = 3'd1;
    localparam logic [ACT_W-1:0] ACT_LOW    = 3'd2;
    localparam logic [ACT_W-1:0] ACT_HIZ    = 3'd3;
    localparam logic [ACT_W-1:0] ACT_TOGGLE = 3'd4;
endpackage

// File: rtl/tz_trip_state.sv
module tz_trip_state #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fault_in,
    input  logic [NSRC-1:0] os_en,
    input  logic [NSRC-1:0] cb_en,
    input  logic            ctr_zero,
    input  logic            sw_clr,
    input  logic            irq_en,
    output logic            os_live,
    output logic            cb_live,
    output logic            os_q_o,
    output logic            cb_q_o,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic            os;
        logic            cb;
        logic            irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        os_live = |(fault_in & os_en);
        cb_live = |(fault_in & cb_en);
        st_d = st_q;
        // latched class: set wins over clear
        if (os_live)       st_d.os = 1'b1;
        else if (sw_clr)   st_d.os = 1'b0;
        // per-cycle class: release only at counter zero with input gone
        if (cb_live)       st_d.cb = 1'b1;
        else if (ctr_zero) st_d.cb = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (fault_in[i])  st_d.flags[i] = 1'b1;
            else if (sw_clr)  st_d.flags[i] = 1'b0;
        end
        if (irq_en && (os_live || cb_live)) st_d.irq = 1'b1;
        else if (sw_clr)                    st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign os_q_o  = st_q.os;
    assign cb_q_o  = st_q.cb;
    assign flags_o = st_q.flags;
    assign irq_o   = st_q.irq;

    AST_OS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.os && !sw_clr) |=> st_q.os); // R3
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        os_live |=> st_q.os); // R4
    AST_CB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cb && !ctr_zero) |=> st_q.cb); // R5
    AST_CB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cb && ctr_zero && !cb_live) |=> !st_q.cb); // R5
    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in != '0) |=> ((st_q.flags & $past(fault_in)) == $past(fault_in))); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.irq && !irq_en) |=> !st_q.irq); // R11
endmodule

// File: rtl/tz_pin_ctl.sv
module tz_pin_ctl
    import tz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [ACT_W-1:0] os_act,
    input  logic [ACT_W-1:0] cb_act,
    input  logic             os_on,
    input  logic             cb_on,
    input  logic             ctr_zero,
    output logic             pin,
    output logic             oe
);
    logic [ACT_W-1:0] sel;
    logic             tripped;
    logic             tog_mode;
    logic             tog_d, tog_q;

    always_comb begin
        tripped  = os_on || cb_on;
        sel      = os_on ? os_act : (cb_on ? cb_act : ACT_PASS);
        tog_mode = tripped && (sel == ACT_TOGGLE);
        pin = 1'b0;
        oe  = 1'b1;
        case (sel)
            ACT_PASS:   pin = pwm_in;
            ACT_HIGH:   pin = 1'b1;
            ACT_LOW:    pin = 1'b0;
            ACT_HIZ:    oe  = 1'b0;
            ACT_TOGGLE: pin = tog_q;
            default:    pin = 1'b0;
        endcase
        if (tog_mode) tog_d = ctr_zero ? ~tog_q : tog_q;
        else          tog_d = ~pwm_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    AST_HIZ_ONLY_TRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> tripped); // R7
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_mode && ctr_zero) |=> (tog_q != $past(tog_q))); // R8
    AST_TOG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_mode && !ctr_zero) |=> $stable(tog_q)); // R8
endmodule

// File: rtl/tz_guard.sv
module tz_guard
    import tz_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic [NSRC-1:0]  fault_in,
    input  logic [NSRC-1:0]  os_en,
    input  logic [NSRC-1:0]  cb_en,
    input  logic [ACT_W-1:0] os_act_a,
    input  logic [ACT_W-1:0] os_act_b,
    input  logic [ACT_W-1:0] cb_act_a,
    input  logic [ACT_W-1:0] cb_act_b,
    input  logic             ctr_zero,
    input  logic             sw_clr,
    input  logic             irq_en,
    output logic             pwm_a_out,
    output logic             pwm_b_out,
    output logic             oe_a,
    output logic             oe_b,
    output logic [NSRC-1:0]  src_flags,
    output logic             os_flag,
    output logic             cb_flag,
    output logic             irq
);
    localparam int NPIN = 2;

    logic os_live, cb_live, os_q, cb_q;
    logic os_on, cb_on;
    logic [NPIN-1:0] pin_in, pin_out, pin_oe;
    logic [NPIN-1:0][ACT_W-1:0] os_act_v, cb_act_v;

    tz_trip_state #(.NSRC(NSRC)) i_state (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .os_en(os_en),
        .cb_en(cb_en), .ctr_zero(ctr_zero), .sw_clr(sw_clr), .irq_en(irq_en),
        .os_live(os_live), .cb_live(cb_live), .os_q_o(os_q), .cb_q_o(cb_q),
        .flags_o(src_flags), .irq_o(irq)
    );

    assign os_on    = os_live || os_q;
    assign cb_on    = cb_live || cb_q;
    assign pin_in   = {pwm_b_in, pwm_a_in};
    assign os_act_v = {os_act_b, os_act_a};
    assign cb_act_v = {cb_act_b, cb_act_a};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        tz_pin_ctl i_pin (
            .clk(clk), .rst_n(rst_n), .pwm_in(pin_in[p]),
            .os_act(os_act_v[p]), .cb_act(cb_act_v[p]),
            .os_on(os_on), .cb_on(cb_on), .ctr_zero(ctr_zero),
            .pin(pin_out[p]), .oe(pin_oe[p])
        );
    end

    assign pwm_a_out = pin_out[0];
    assign pwm_b_out = pin_out[1];
    assign oe_a      = pin_oe[0];
    assign oe_b      = pin_oe[1];
    assign os_flag   = os_q;
    assign cb_flag   = cb_q;

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_on && !cb_on) |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in && oe_a && oe_b)); // R2
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_in & (os_en | cb_en)) == '0 && !os_q && !cb_q) |-> (oe_a && oe_b)); // R9
endmodule

// File: tb/test_tz_guard.sv
module test_tz_guard;
    localparam int NSRC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a_in = 1'b0, pwm_b_in = 1'b0;
    logic [NSRC-1:0] fault_in = '0, os_en = '0, cb_en = '0;
    logic [2:0] os_act_a = '0, os_act_b = '0, cb_act_a = '0, cb_act_b = '0;
    logic ctr_zero = 1'b0, sw_clr = 1'b0, irq_en = 1'b0;
    logic pwm_a_out, pwm_b_out, oe_a, oe_b, os_flag, cb_flag, irq;
    logic [NSRC-1:0] src_flags;

    int total = 0, bad = 0, ph = 0;
    bit done = 0;

    // reference state
    bit m_os, m_cb, m_irq, m_tog_a, m_tog_b;
    bit [NSRC-1:0] m_flags;

    always #10 clk = ~clk;

    tz_guard #(.NSRC(NSRC)) i_tz_guard (
        .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .fault_in(fault_in), .os_en(os_en), .cb_en(cb_en),
        .os_act_a(os_act_a), .os_act_b(os_act_b), .cb_act_a(cb_act_a), .cb_act_b(cb_act_b),
        .ctr_zero(ctr_zero), .sw_clr(sw_clr), .irq_en(irq_en),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out), .oe_a(oe_a), .oe_b(oe_b),
        .src_flags(src_flags), .os_flag(os_flag), .cb_flag(cb_flag), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // expected {oe, pin} for one output
    function automatic int exp_pin(bit pwm, int osa, int cba, bit os_on, bit cb_on, bit tog);
        int a;
        if (os_on) a = osa; else if (cb_on) a = cba; else a = 0;
        if (a == 0) return 2 + pwm;
        if (a == 1) return 3;
        if (a == 3) return 0;
        if (a == 4) return 2 + tog;
        return 2;
    endfunction

    function automatic bit next_tog(bit pwm, int osa, int cba, bit os_on, bit cb_on, bit tog, bit cz);
        int a;
        if (!(os_on || cb_on)) return !pwm;
        a = os_on ? osa : cba;
        if (a != 4) return !pwm;
        return cz ? !tog : tog;
    endfunction

    task automatic cyc(input string tag);
        bit lo, lc, oon, con, na, nb;
        @(negedge clk);
        lo  = |(fault_in & os_en);
        lc  = |(fault_in & cb_en);
        oon = m_os || lo;
        con = m_cb || lc;
        chk(tag, "a", {oe_a, pwm_a_out}, exp_pin(pwm_a_in, os_act_a, cb_act_a, oon, con, m_tog_a));
        chk(tag, "b", {oe_b, pwm_b_out}, exp_pin(pwm_b_in, os_act_b, cb_act_b, oon, con, m_tog_b));
        chk(tag, "os_flag", os_flag, m_os);
        chk(tag, "cb_flag", cb_flag, m_cb);
        chk(tag, "src_flags", src_flags, m_flags);
        chk(tag, "irq", irq, m_irq);
        na = next_tog(pwm_a_in, os_act_a, cb_act_a, oon, con, m_tog_a, ctr_zero);
        nb = next_tog(pwm_b_in, os_act_b, cb_act_b, oon, con, m_tog_b, ctr_zero);
        @(posedge clk);
        #1;
        if (lo) m_os = 1; else if (sw_clr) m_os = 0;
        if (lc) m_cb = 1; else if (ctr_zero) m_cb = 0;
        for (int i = 0; i < NSRC; i++)
            if (fault_in[i]) m_flags[i] = 1; else if (sw_clr) m_flags[i] = 0;
        if (irq_en && (lo || lc)) m_irq = 1; else if (sw_clr) m_irq = 0;
        m_tog_a = na;
        m_tog_b = nb;
        ph++;
        pwm_a_in = ph[1];
        pwm_b_in = ~ph[0] ^ ph[2];
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_os = 0; m_cb = 0; m_irq = 0; m_tog_a = 0; m_tog_b = 0; m_flags = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: state right after reset
        cyc("R1");
        chk("R1", "irq_reset", irq, 0);
        chk("R1", "flags_reset", src_flags, 0);
        // R2: pass-through under a moving pattern
        repeat (8) cyc("R2");
        // R5: per-cycle trip, ctr_zero during fault must not release
        cb_en = 6'b000010; cb_act_a = 3'd2; cb_act_b = 3'd1; fault_in = 6'b000010;
        repeat (3) cyc("R5");
        ctr_zero = 1; cyc("R5"); ctr_zero = 0;
        fault_in = '0;
        repeat (3) cyc("R5");
        chk("R5", "cb_held", cb_flag, 1);
        ctr_zero = 1; cyc("R5"); ctr_zero = 0;
        repeat (2) cyc("R5");
        chk("R5", "cb_released", cb_flag, 0);
        chk("R11", "irq_disabled", irq, 0);
        sw_clr = 1; cyc("R10"); sw_clr = 0;
        cyc("R10");
        // R3/R4/R8: latched trip with hi-z on A and toggle on B
        cb_en = '0; os_en = 6'b000001; os_act_a = 3'd3; os_act_b = 3'd4; irq_en = 1;
        fault_in = 6'b000001;
        repeat (2) cyc("R3");
        sw_clr = 1; repeat (2) cyc("R4"); sw_clr = 0;
        chk("R4", "os_kept", os_flag, 1);
        for (int k = 0; k < 6; k++) begin
            ctr_zero = k[0]; cyc("R8");
        end
        ctr_zero = 0; fault_in = '0;
        for (int k = 0; k < 4; k++) begin
            ctr_zero = k[0]; cyc("R3");
        end
        ctr_zero = 0;
        chk("R11", "irq_set", irq, 1);
        sw_clr = 1; cyc("R3"); sw_clr = 0;
        repeat (2) cyc("R3");
        chk("R3", "os_cleared", os_flag, 0);
        // R6: both classes, opposite actions
        os_en = 6'b000001; cb_en = 6'b000100;
        os_act_a = 3'd1; os_act_b = 3'd2; cb_act_a = 3'd2; cb_act_b = 3'd1;
        fault_in = 6'b000100; repeat (2) cyc("R6");
        fault_in = 6'b000101; repeat (2) cyc("R6");
        os_act_a = 3'd0; repeat (2) cyc("R6");
        fault_in = '0; sw_clr = 1; ctr_zero = 1; cyc("R6");
        sw_clr = 0; ctr_zero = 0; repeat (2) cyc("R6");
        // R9/R10: all inputs with no enables
        os_en = '0; cb_en = '0; fault_in = '1;
        repeat (4) cyc("R9");
        sw_clr = 1; cyc("R10");
        fault_in = 6'b101010; cyc("R10");
        fault_in = '0; cyc("R10"); sw_clr = 0;
        cyc("R10");
        // R7: all action codes on both outputs
        os_en = 6'b100000;
        for (int k = 0; k < 8; k++) begin
            os_act_a = 3'(k); os_act_b = 3'(7 - k);
            fault_in = 6'b100000; repeat (2) cyc("R7");
            fault_in = '0; sw_clr = 1; cyc("R7"); sw_clr = 0;
            cyc("R7");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule